// File: doc/BRIEF.md
# Trigger Matching Hit Selector

This block sits behind the time-measurement front end of a multi-channel time-to-digital converter. It receives one already-digitized hit per cycle (channel number plus fine-time bits) and stamps each accepted hit with a free-running 12-bit coarse counter. Accepted hits wait in a small circular buffer. A trigger pulse captures the coarse counter value as its tag and joins a queue. For each queued trigger the block searches the buffer for hits inside a matching window. That window begins a programmable latency before the trigger tag and spans a programmable number of coarse ticks.

Each event is written into a readout FIFO. Framing is optional: when enabled, a header word comes first, then the matched hits oldest first, then a trailer word. Per channel, the block applies a dead time and an enable mask. The number of hits kept per event is capped. Time fields can be absolute or relative to the trigger tag. A bypass mode skips matching and writes every accepted hit straight to the readout FIFO. The consumer reads the FIFO through a show-ahead data port and a pop strobe.

Top module: `tm_trigger_match`

## Requirements
- R1: After reset the readout FIFO is empty (`ro_empty` = 1), and the coarse counter reads 0 on the first clock edge after reset is released. The counter then advances by one per cycle, modulo 4096.
- R2: A buffered hit with coarse time h matches a trigger with tag T when (h − (T − latency)) mod 4096 < window. Each matched hit becomes one data word: bits [18:17]=00, [16:15]=channel, [14:3]=time, [2:0]=fine. Hits outside the window produce no data word.
- R3: When relative mode is on, the data time field is (h − T) mod 4096. Otherwise it is h.
- R4: With framing on, each event is a header followed by its data words and then a trailer. The header has [18:17]=10, [14:3]=T and all other bits 0. The trailer has [18:17]=11, [16]=drop flag, [7:0]=data word count and all other bits 0. With framing off, only data words are written.
- R5: An event writes at most `cfg_hit_limit` data words. Further matched hits are dropped, and the event's trailer drop flag is set.
- R6: Triggers are queued in a 16-entry queue. Sixteen triggers on consecutive cycles each produce their own event, in arrival order.
- R7: A word written while the readout FIFO already holds `cfg_ro_depth` words is discarded.
- R8: After an accepted hit on a channel, hits on that same channel during the next `cfg_dead` cycles are ignored. Other channels are not affected.
- R9: A hit on a channel whose `cfg_ch_en` bit is 0 is ignored.
- R10: In bypass mode, every accepted hit is written at once as a data word with its absolute time. Triggers produce nothing.
- R11: A window that spans the counter wrap from 4095 to 0 matches hits on both sides of the wrap.
- R12: The hit buffer holds 16 hits. A hit arriving while it is full is dropped, and the drop flag is set in the trailer of the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bypass | input | 1 | 1: pass hits straight to readout, no matching |
| cfg_rel | input | 1 | 1: data time relative to trigger tag |
| cfg_frame | input | 1 | 1: enclose events in header and trailer |
| cfg_latency | input | 12 | Coarse ticks from window start to trigger tag |
| cfg_window | input | 12 | Window width in coarse ticks |
| cfg_hit_limit | input | 8 | Maximum data words per event |
| cfg_ro_depth | input | 9 | Usable readout FIFO depth (1..256) |
| cfg_dead | input | 4 | Per-channel dead time in cycles |
| cfg_ch_en | input | 4 | Per-channel enable mask |
| hit_valid | input | 1 | A hit word is present this cycle |
| hit_ch | input | 2 | Channel of the hit |
| hit_fine | input | 3 | Fine-time bits of the hit |
| trig | input | 1 | Trigger pulse |
| ro_rd | input | 1 | Pop the readout FIFO head |
| ro_data | output | 19 | Readout FIFO head word |
| ro_empty | output | 1 | Readout FIFO is empty |

## Verification
The bench uses the default build: four channels, a 16-entry hit buffer, a 16-entry trigger queue, a 256-word readout FIFO and a 12-bit coarse counter. With these sizes, a buffer overflow needs only seventeen hits. A full trigger queue needs sixteen back-to-back pulses. The counter wrap falls about four thousand cycles after reset, so all three corners are reached in a short run. Latency 20 and window 18 put both window edges a few ticks from the trigger, which lets single hits probe each boundary. A usable readout depth of 3 truncates an event in the middle.

// File: rtl/tm_pkg.sv
// Shared widths and word layout for the trigger matching hit selector.
// Assumes a fixed channel count and a 12-bit coarse time base.
package tm_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int CW  = 12;
    localparam int FW  = 3;
    localparam int W   = 2 + CHW + CW + FW;

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic [CW-1:0]  coarse;
        logic [FW-1:0]  fine;
    } hit_t;

    localparam logic [1:0] WT_DATA  = 2'b00;
    localparam logic [1:0] WT_HEAD  = 2'b10;
    localparam logic [1:0] WT_TRAIL = 2'b11;
endpackage

// File: rtl/tm_fifo.sv
// Synchronous FIFO with a run-time occupancy limit.
// Writes that find the FIFO full and reads that find it empty are ignored.
// Assumes DEPTH is a power of two and lim lies in 1..DEPTH.
module tm_fifo #(
    parameter int WD    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WD-1:0] din,
    input  logic          pop,
    input  logic [AW:0]   lim,
    output logic [WD-1:0] dout,
    output logic          empty,
    output logic          full
);
    logic [WD-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt >= lim);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    // R7
    occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
endmodule

// File: rtl/tm_hit_front.sv
// Hit front end: coarse time base, channel enable mask and per-channel
// dead time. A hit is accepted when valid, enabled and its channel is
// not dead, and it is stamped with the current coarse count.
module tm_hit_front import tm_pkg::*; #(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [CHW-1:0]    hit_ch,
    input  logic [FW-1:0]     hit_fine,
    input  logic [NCH-1:0]    ch_en,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic [CW-1:0]     tnow,
    output logic              acc,
    output hit_t              acc_hit
);
    logic [NCH-1:0] busy;

    // Free-running coarse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tnow <= '0;
        else        tnow <= tnow + 1'b1;
    end

    assign acc     = hit_valid && ch_en[hit_ch] && !busy[hit_ch];
    assign acc_hit = '{ch: hit_ch, coarse: tnow, fine: hit_fine};

    for (genvar g = 0; g < NCH; g++) begin : g_dead
        logic [DEAD_W-1:0] left_q;
        assign busy[g] = (left_q != '0);
        // Reload on an accepted hit of this channel, else count down.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     left_q <= '0;
            else if (acc && hit_ch == CHW'(g))              left_q <= dead_cycles;
            else if (left_q != '0)                          left_q <= left_q - 1'b1;
        end
    end

    // R8
    dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dead_cycles != '0) |=> !(acc && acc_hit.ch == $past(acc_hit.ch)));
endmodule

// File: rtl/tm_scan.sv
// Circular hit buffer and per-trigger matching engine. For the trigger at
// the head of the queue it writes an optional header, walks the buffer
// oldest first (discarding hits older than the window, emitting hits
// inside it up to the event limit) and stops at the first newer hit,
// then writes an optional trailer and pops the trigger.
// Assumes window <= latency, so all window hits precede the trigger.
module tm_scan import tm_pkg::*; #(
    parameter int HD    = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit_in,
    input  hit_t             hit_word,
    input  logic             tq_empty,
    input  logic [CW-1:0]    tq_tag,
    output logic             tq_pop,
    input  logic [CW-1:0]    cfg_latency,
    input  logic [CW-1:0]    cfg_window,
    input  logic [CNT_W-1:0] cfg_hit_limit,
    input  logic             cfg_rel,
    input  logic             cfg_frame,
    input  logic             ro_full,
    output logic             ro_we,
    output logic [W-1:0]     ro_word
);
    localparam int HAW = $clog2(HD);

    typedef enum logic [1:0] {S_IDLE, S_HEAD, S_SCAN, S_TRAIL} st_e;

    st_e              state;
    hit_t             buf_q [HD];
    logic [HAW:0]     wp, tp, ptr, occ;
    logic             hb_full, ovf, ev_flag;
    logic [CNT_W-1:0] ev_cnt;
    hit_t             cur;
    logic [CW-1:0]    wstart, diff, tfield;
    logic             at_end, too_old, in_win, keep;

    assign occ     = wp - tp;
    assign hb_full = (occ == (HAW+1)'(HD));
    assign cur     = buf_q[ptr[HAW-1:0]];
    assign wstart  = tq_tag - cfg_latency;
    assign diff    = cur.coarse - wstart;
    assign at_end  = (ptr == wp);
    assign too_old = diff[CW-1];
    assign in_win  = !too_old && (diff < cfg_window);
    assign keep    = (ev_cnt < cfg_hit_limit) && !ro_full;
    assign tfield  = cfg_rel ? (cur.coarse - tq_tag) : cur.coarse;

    // Hit buffer storage write.
    always_ff @(posedge clk) begin
        if (hit_in && !hb_full) buf_q[wp[HAW-1:0]] <= hit_word;
    end

    // Output word and strobes for the current state.
    always_comb begin
        ro_we   = 1'b0;
        ro_word = '0;
        tq_pop  = 1'b0;
        case (state)
            S_HEAD:  begin
                ro_we   = cfg_frame;
                ro_word = {WT_HEAD, {CHW{1'b0}}, tq_tag, {FW{1'b0}}};
            end
            S_SCAN:  begin
                ro_we   = !at_end && in_win && keep;
                ro_word = {WT_DATA, cur.ch, tfield, cur.fine};
            end
            S_TRAIL: begin
                ro_we   = cfg_frame;
                ro_word = {WT_TRAIL, ev_flag, {(W-3-CNT_W){1'b0}}, ev_cnt};
                tq_pop  = 1'b1;
            end
            default: ;
        endcase
    end

    // Buffer pointers, drop flag and matching state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wp      <= '0;
            tp      <= '0;
            ptr     <= '0;
            ovf     <= 1'b0;
            ev_flag <= 1'b0;
            ev_cnt  <= '0;
        end else begin
            if (hit_in && !hb_full) wp <= wp + 1'b1;
            ovf <= (ovf && state != S_HEAD) || (hit_in && hb_full);
            case (state)
                S_IDLE:  if (en && !tq_empty) state <= S_HEAD;
                S_HEAD:  begin
                    ptr     <= tp;
                    ev_cnt  <= '0;
                    ev_flag <= ovf;
                    state   <= S_SCAN;
                end
                S_SCAN:  begin
                    if (at_end) begin
                        state <= S_TRAIL;
                    end else if (too_old) begin
                        tp  <= ptr + 1'b1;
                        ptr <= ptr + 1'b1;
                    end else if (in_win) begin
                        if (keep) ev_cnt  <= ev_cnt + 1'b1;
                        else      ev_flag <= 1'b1;
                        ptr <= ptr + 1'b1;
                    end else begin
                        state <= S_TRAIL;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R5
    hit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN) |-> (ev_cnt <= cfg_hit_limit));
    // R12
    buf_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (HAW+1)'(HD));
    // R4
    trail_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tq_pop |=> (state == S_IDLE));
endmodule

// File: rtl/tm_trigger_match.sv
// Top of the trigger matching hit selector: hit front end, trigger tag
// queue, matching engine and readout FIFO. In bypass mode accepted hits
// go straight to readout and triggers are not queued.
// Assumes configuration changes only while no event is in progress.
module tm_trigger_match import tm_pkg::*; #(
    parameter int HIT_DEPTH  = 16,
    parameter int TRIG_DEPTH = 16,
    parameter int RO_DEPTH   = 256,
    parameter int DEAD_W     = 4,
    parameter int CNT_W      = 8,
    localparam int RO_AW     = $clog2(RO_DEPTH),
    localparam int TQ_AW     = $clog2(TRIG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic              cfg_rel,
    input  logic              cfg_frame,
    input  logic [CW-1:0]     cfg_latency,
    input  logic [CW-1:0]     cfg_window,
    input  logic [CNT_W-1:0]  cfg_hit_limit,
    input  logic [RO_AW:0]    cfg_ro_depth,
    input  logic [DEAD_W-1:0] cfg_dead,
    input  logic [NCH-1:0]    cfg_ch_en,
    input  logic              hit_valid,
    input  logic [CHW-1:0]    hit_ch,
    input  logic [FW-1:0]     hit_fine,
    input  logic              trig,
    input  logic              ro_rd,
    output logic [W-1:0]      ro_data,
    output logic              ro_empty
);
    logic          acc, tq_empty, tq_full, tq_pop, ro_full, sc_we, ro_push;
    hit_t          acc_hit;
    logic [CW-1:0] tnow, tq_tag;
    logic [W-1:0]  sc_word, ro_din;

    tm_hit_front #(.DEAD_W(DEAD_W)) u_front (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ch(hit_ch),
        .hit_fine(hit_fine), .ch_en(cfg_ch_en), .dead_cycles(cfg_dead),
        .tnow(tnow), .acc(acc), .acc_hit(acc_hit));

    tm_fifo #(.WD(CW), .DEPTH(TRIG_DEPTH)) u_tq (
        .clk(clk), .rst_n(rst_n), .push(trig && !cfg_bypass), .din(tnow),
        .pop(tq_pop), .lim((TQ_AW+1)'(TRIG_DEPTH)), .dout(tq_tag),
        .empty(tq_empty), .full(tq_full));

    tm_scan #(.HD(HIT_DEPTH), .CNT_W(CNT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .en(!cfg_bypass), .hit_in(acc && !cfg_bypass),
        .hit_word(acc_hit), .tq_empty(tq_empty), .tq_tag(tq_tag), .tq_pop(tq_pop),
        .cfg_latency(cfg_latency), .cfg_window(cfg_window),
        .cfg_hit_limit(cfg_hit_limit), .cfg_rel(cfg_rel), .cfg_frame(cfg_frame),
        .ro_full(ro_full), .ro_we(sc_we), .ro_word(sc_word));

    assign ro_push = cfg_bypass ? acc : sc_we;
    assign ro_din  = cfg_bypass ? {WT_DATA, acc_hit} : sc_word;

    tm_fifo #(.WD(W), .DEPTH(RO_DEPTH)) u_ro (
        .clk(clk), .rst_n(rst_n), .push(ro_push), .din(ro_din), .pop(ro_rd),
        .lim(cfg_ro_depth), .dout(ro_data), .empty(ro_empty), .full(ro_full));

    // R6
    trig_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_full && !tq_pop) |=> !tq_empty);
    // R10
    bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |-> !tq_pop);
endmodule

// File: tb/sim_tm_trigger_match.sv
`timescale 1ns/1ps
module sim_tm_trigger_match;
    import tm_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_bypass = 0, cfg_rel = 0, cfg_frame = 1;
    logic [CW-1:0] cfg_latency = 12'd20, cfg_window = 12'd18;
    logic [7:0] cfg_hit_limit = 8'd255;
    logic [8:0] cfg_ro_depth = 9'd256;
    logic [3:0] cfg_dead = 4'd0;
    logic [NCH-1:0] cfg_ch_en = '1;
    logic hit_valid = 0, trig = 0, ro_rd = 0;
    logic [CHW-1:0] hit_ch = '0;
    logic [FW-1:0] hit_fine = '0;
    logic [W-1:0] ro_data;
    logic ro_empty;

    int bcyc = 0, nchk = 0, nerr = 0;
    logic [W-1:0] got_q[$], exp_q[$];

    // Table: distance from hit to trigger, channel, fine, expected match
    localparam int NV = 6;
    localparam int VD[NV] = '{21, 20, 3, 2, 10, 1};
    localparam int VC[NV] = '{0, 1, 2, 3, 1, 0};
    localparam int VF[NV] = '{1, 2, 3, 4, 5, 6};
    localparam int VM[NV] = '{0, 1, 1, 0, 1, 0};

    tm_trigger_match u0 (.*);

    always #2 clk = ~clk;
    always @(posedge clk) bcyc <= rst_n ? bcyc + 1 : 0;

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(string req, string what, int got, int exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [W-1:0] f_hdr(int t);
        return {2'b10, {CHW{1'b0}}, t[CW-1:0], {FW{1'b0}}};
    endfunction
    function automatic logic [W-1:0] f_dat(int c, int t, int f);
        return {2'b00, c[CHW-1:0], t[CW-1:0], f[FW-1:0]};
    endfunction
    function automatic logic [W-1:0] f_trl(int fl, int n);
        return {2'b11, fl[0], {(W-11){1'b0}}, n[7:0]};
    endfunction

    task automatic send_hit(int c, int f, output int tag);
        hit_valid = 1; hit_ch = c[CHW-1:0]; hit_fine = f[FW-1:0];
        tag = bcyc % 4096;
        tick();
        hit_valid = 0;
    endtask
    task automatic send_trig(output int tag);
        trig = 1; tag = bcyc % 4096;
        tick();
        trig = 0;
    endtask
    task automatic drain();
        got_q.delete();
        while (!ro_empty) begin
            got_q.push_back(ro_data);
            ro_rd = 1;
            tick();
        end
        ro_rd = 0;
    endtask
    task automatic compare(string req);
        chk(req, "word count", got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(req, $sformatf("word %0d", i), int'(got_q[i]), int'(exp_q[i]));
        exp_q.delete();
    endtask
    task automatic flush();
        int t;
        repeat (40) tick();
        send_trig(t);
        repeat (60) tick();
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int h, t, hs[20];
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: empty after reset
        chk("R1", "ro_empty", int'(ro_empty), 1);

        // R2 R1: table of single-hit windows, latency 20 window 18
        for (int i = 0; i < NV; i++) begin
            send_hit(VC[i], VF[i], h);
            repeat (VD[i] - 1) tick();
            send_trig(t);
            repeat (40) tick();
            drain();
            exp_q.push_back(f_hdr(t));
            if (VM[i] == 1) exp_q.push_back(f_dat(VC[i], h, VF[i]));
            exp_q.push_back(f_trl(0, VM[i]));
            compare($sformatf("R2 vec%0d", i));
        end

        // R5: limit 4, six hits in window
        cfg_hit_limit = 4;
        for (int i = 0; i < 6; i++) send_hit(i % 4, i, hs[i]);
        repeat (4) tick();
        send_trig(t);
        repeat (40) tick();
        drain();
        exp_q.push_back(f_hdr(t));
        for (int i = 0; i < 4; i++) exp_q.push_back(f_dat(i, hs[i], i));
        exp_q.push_back(f_trl(1, 4));
        compare("R5");
        cfg_hit_limit = 255;
        flush();

        // R3: relative time
        cfg_rel = 1;
        send_hit(3, 5, h);
        repeat (9) tick();
        send_trig(t);
        repeat (40) tick();
        drain();
        exp_q.push_back(f_hdr(t));
        exp_q.push_back(f_dat(3, (h - t + 4096) % 4096, 5));
        exp_q.push_back(f_trl(0, 1));
        compare("R3");
        cfg_rel = 0;
        flush();

        // R4: framing off
        cfg_frame = 0;
        send_hit(2, 7, h);
        repeat (4) tick();
        send_trig(t);
        repeat (40) tick();
        drain();
        exp_q.push_back(f_dat(2, h, 7));
        compare("R4");
        cfg_frame = 1;
        flush();

        // R7: usable readout depth 3
        cfg_ro_depth = 3;
        for (int i = 0; i < 3; i++) send_hit(i, 1, hs[i]);
        repeat (7) tick();
        send_trig(t);
        repeat (40) tick();
        drain();
        exp_q.push_back(f_hdr(t));
        exp_q.push_back(f_dat(0, hs[0], 1));
        exp_q.push_back(f_dat(1, hs[1], 1));
        compare("R7");
        cfg_ro_depth = 256;
        flush();

        // R6: sixteen back-to-back triggers
        repeat (40) tick();
        for (int i = 0; i < 16; i++) begin
            send_trig(t);
            exp_q.push_back(f_hdr(t));
            exp_q.push_back(f_trl(0, 0));
        end
        repeat (150) tick();
        drain();
        compare("R6");

        // R12: seventeen hits into a 16-entry buffer
        for (int i = 0; i < 17; i++) send_hit(i % 4, i % 8, hs[i]);
        repeat (3) tick();
        send_trig(t);
        repeat (60) tick();
        drain();
        exp_q.push_back(f_hdr(t));
        for (int i = 0; i < 16; i++) exp_q.push_back(f_dat(i % 4, hs[i], i % 8));
        exp_q.push_back(f_trl(1, 16));
        compare("R12");
        flush();

        // R11: window across counter wrap
        while ((bcyc % 4096) != 4094) tick();
        for (int i = 0; i < 3; i++) send_hit(i, 3, hs[i]);
        while ((bcyc % 4096) != 15) tick();
        send_trig(t);
        repeat (40) tick();
        drain();
        exp_q.push_back(f_hdr(15));
        exp_q.push_back(f_dat(0, 4094, 3));
        exp_q.push_back(f_dat(1, 4095, 3));
        exp_q.push_back(f_dat(2, 0, 3));
        exp_q.push_back(f_trl(0, 3));
        compare("R11");
        chk("R11", "trigger tag", t, 15);
        flush();

        // R10: bypass, trigger produces nothing
        cfg_bypass = 1;
        send_hit(1, 2, hs[0]);
        send_trig(t);
        send_hit(2, 6, hs[1]);
        repeat (20) tick();
        drain();
        exp_q.push_back(f_dat(1, hs[0], 2));
        exp_q.push_back(f_dat(2, hs[1], 6));
        compare("R10");

        // R8: dead time 3 on channel 1, channel 0 unaffected
        cfg_dead = 3;
        send_hit(1, 1, hs[0]);
        send_hit(0, 2, hs[1]);
        send_hit(1, 3, hs[2]);
        tick();
        send_hit(1, 4, hs[3]);
        repeat (10) tick();
        drain();
        exp_q.push_back(f_dat(1, hs[0], 1));
        exp_q.push_back(f_dat(0, hs[1], 2));
        exp_q.push_back(f_dat(1, hs[3], 4));
        compare("R8");
        cfg_dead = 0;

        // R9: channel 2 disabled
        cfg_ch_en = 4'b1011;
        send_hit(2, 5, hs[0]);
        tick();
        chk("R9", "ro_empty after disabled hit", int'(ro_empty), 1);
        send_hit(3, 5, hs[1]);
        repeat (5) tick();
        drain();
        exp_q.push_back(f_dat(3, hs[1], 5));
        compare("R9");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule